// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a bus host read and write access to a small bank of 8-bit registers. SCL and SDA are sampled by a faster system clock through a two-flop synchronizer. The block detects START and STOP conditions on the synchronized lines and recognises a 7-bit device address. That address is a fixed 5-bit prefix followed by two bits taken from strap inputs, which are captured while reset is held. The block shifts bytes in and out, drives the acknowledge bit, and keeps a register pointer that can advance on its own after each byte.

A host writes by sending the device address with the direction bit low, then a pointer byte, then any number of data bytes. A read cannot load the pointer. To prepare a read, the host sends a write that stops right after the pointer byte, then starts a new transfer with the direction bit high. The target reads back registers from the current pointer. The target only pulls SDA low through an open-drain enable and never drives it high.

Top module: `i2c_reg_port`

## Requirements
- R1: After reset, sda_oe is 0, every register holds 0x00, the pointer is 0 and auto-increment is off.
- R2: The first byte after a START is compared as seven address bits (MSB first) plus a direction bit in the least significant position (1 = read). The address is 1,0,0,1,1 followed by the latched high strap and then the latched low strap. On a match, the target pulls SDA low during the ninth SCL pulse.
- R3: On an address mismatch, the target gives no ACK. It drives SDA on no later bit and writes no register until the next START or STOP.
- R4: In a write, the byte after the address is the pointer byte and is acknowledged. Bit 7 turns auto-increment on (1) or off (0), and bits 6:0 select the register.
- R5: Each data byte of a write is acknowledged and stored in the register the pointer selects. With auto-increment on, the pointer then advances by one. With it off, the pointer stays, so later bytes overwrite the same register.
- R6: A read returns the selected register MSB first and releases SDA during the host's acknowledge bit. After a host ACK, the next byte follows. After a NACK, the target drives nothing until the next START. With auto-increment on, the pointer advances by one after each byte sent; a read changes the pointer in no other way.
- R7: A write that is stopped right after the pointer byte's ACK keeps the new pointer and auto-increment setting for a later read.
- R8: A START in the middle of any byte returns the target to address reception. The partial byte is dropped and writes nothing.
- R9: The strap inputs are read only while reset is asserted. Changing them afterwards does not change the address the target answers.
- R10: Writes to register indexes at or above NUM_REGS are dropped, and reads from them return 0x00. The pointer is 7 bits wide and wraps from 127 to 0.
- R11: The target raises sda_oe only just after a falling SCL edge, and never while the host is driving a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset; straps are captured while it is low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_hi | input | 1 | Strap for the higher of the two low address bits |
| strap_lo | input | 1 | Strap for the lowest address bit |
| sda_oe | output | 1 | 1 pulls SDA low (open drain); 0 releases it |

## Verification
The falling SCL edge that ends a write data byte does two things in the same cycle: it stores the byte and it advances the pointer. When the pointer sits at 127 with auto-increment on, that same cycle must also drop an out-of-range write and wrap the pointer to 0. The bench provokes both cases with back-to-back auto-incremented writes, including one that starts at register 127. It then reads the registers back through a separate pointer-only write. A behavioural model tracks registers, pointer and bus ownership, and is compared against the open-drain enable on every clock and against each byte returned.

// File: rtl/i2c_port_pkg.sv
package i2c_port_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } port_state_t;

  // Full 7-bit device address from the fixed prefix and the latched straps.
  function automatic logic [6:0] dev_address(input logic [4:0] prefix,
                                             input logic [1:0] strap);
    return {prefix, strap};
  endfunction

  // Pointer value after one byte has been transferred.
  function automatic logic [6:0] ptr_after(input logic [6:0] ptr,
                                           input logic       inc);
    return inc ? ptr + 7'd1 : ptr;
  endfunction

  function automatic logic is_start(input logic scl_prev, input logic scl_now,
                                    input logic sda_prev, input logic sda_now);
    return scl_prev & scl_now & sda_prev & ~sda_now;
  endfunction

  function automatic logic is_stop(input logic scl_prev, input logic scl_now,
                                   input logic sda_prev, input logic sda_now);
    return scl_prev & scl_now & ~sda_prev & sda_now;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = ~scl_d & scl_s;
  assign scl_fall  = scl_d & ~scl_s;
  assign start_evt = is_start(scl_d, scl_s, sda_d, sda_s);
  assign stop_evt  = is_stop(scl_d, scl_s, sda_d, sda_s);

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_idx == IDX_W'(i)) regs[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
  end

endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_port_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b10011,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_hi,
  input  logic strap_lo,
  output logic sda_oe
);

  localparam int IDX_W = 7;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(8);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [1:0]       strap_q;
  port_state_t      state;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] ptr;
  logic             auto_inc;
  logic             rw_read;
  logic             host_acked;
  logic [7:0]       rd_data;

  // Named internal events (observed by the bound checker)
  logic byte_done, addr_hit, wr_en;
  assign byte_done = scl_fall && (bit_cnt == FULL_CNT);
  assign addr_hit  = (shreg[7:1] == dev_address(ADDR_PREFIX, strap_q));
  assign wr_en     = (state == ST_WDATA) && byte_done;

  // Straps are only captured while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= {strap_hi, strap_lo};
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (ptr),
    .wr_data(shreg),
    .rd_idx (ptr),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      ptr        <= '0;
      auto_inc   <= 1'b0;
      rw_read    <= 1'b0;
      host_acked <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && bit_cnt != FULL_CNT) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit) begin
                rw_read <= shreg[0];
                state   <= ST_ADDR_ACK;
                sda_oe  <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (state == ST_PTR) begin
              ptr      <= shreg[6:0];
              auto_inc <= shreg[7];
              state    <= ST_PTR_ACK;
              sda_oe   <= 1'b1;
            end else begin
              ptr    <= ptr_after(ptr, auto_inc);
              state  <= ST_WDATA_ACK;
              sda_oe <= 1'b1;
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (state == ST_ADDR_ACK && rw_read) begin
              state  <= ST_RDATA;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              sda_oe <= 1'b0;
              state  <= (state == ST_ADDR_ACK) ? ST_PTR : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == FULL_CNT) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b0;
              ptr     <= ptr_after(ptr, auto_inc);
              state   <= ST_RACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            host_acked <= ~sda_s;
          end else if (scl_fall) begin
            if (host_acked) begin
              state  <= ST_RDATA;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk
  import i2c_port_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_s,
  input logic        scl_rise,
  input logic        scl_fall,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        addr_hit,
  input logic        byte_done,
  input logic        wr_en,
  input port_state_t state
);

  // R11
  oe_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R11
  line_event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));

  // R8
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR) && !sda_oe);

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_oe);

  // R3
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && byte_done && !addr_hit) |=> (state == ST_IGNORE) && !sda_oe);

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe);

  // R5
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (state == ST_WDATA_ACK) && sda_oe);

endmodule

bind i2c_reg_port i2c_reg_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .scl_rise (scl_rise),
  .scl_fall (scl_fall),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .addr_hit (addr_hit),
  .byte_done(byte_done),
  .wr_en    (wr_en),
  .state    (state)
);

// File: tb/tb_i2c_reg_port.sv
module tb_i2c_reg_port;

  localparam int NUM_REGS = 16;
  localparam int Q        = 10;  // quarter SCL period in clk cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_host = 1'b1;
  logic strap_hi = 1'b1;
  logic strap_lo = 1'b0;
  logic sda_oe;
  logic sda_line;

  always #10 clk = ~clk;  // 50 MHz

  assign sda_line = sda_host & ~sda_oe;

  i2c_reg_port dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .strap_hi(strap_hi),
    .strap_lo(strap_lo),
    .sda_oe  (sda_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit host_own = 1;

  // Reference model
  int mregs[128];
  int mptr = 0;
  bit minc = 0;
  logic [1:0] mstrap;
  logic [7:0] wq[$];

  // Bus ownership compared against the enable on every clock (R11)
  always @(negedge clk) begin
    if (rst_n && host_own && sda_oe) begin
      errors++;
      $display("FAIL R11 target drove SDA in host phase at %0t actual=1 expected=0", $time);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(logic b, bit last);
    sda_host = b; wt(Q);
    scl = 1'b1;   wt(2*Q);
    scl = 1'b0;
    if (last) host_own = 0;
    wt(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_host = 1'b1; wt(Q);
    scl = 1'b1;      wt(Q);
    b = sda_line;    wt(Q);
    scl = 1'b0;      wt(Q);
  endtask

  task automatic start_c();
    host_own = 1;
    sda_host = 1'b1; wt(Q);
    scl = 1'b1;      wt(Q);
    sda_host = 1'b0; wt(Q);
    scl = 1'b0;      wt(Q);
  endtask

  task automatic stop_c();
    host_own = 1;
    sda_host = 1'b0; wt(Q);
    scl = 1'b1;      wt(Q);
    sda_host = 1'b1; wt(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    logic a;
    host_own = 1;
    for (int i = 7; i >= 0; i--) bit_out(b[i], i == 0);
    bit_in(a);
    acked = !a;
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] d);
    logic b;
    host_own = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    host_own = 1;
    bit_out(give_ack ? 1'b0 : 1'b1, give_ack);
  endtask

  function automatic logic [7:0] addr_byte(logic [1:0] strap, logic rd);
    return {5'b10011, strap, rd};
  endfunction

  function automatic int model_read();
    return (mptr < NUM_REGS) ? mregs[mptr] : 0;
  endfunction

  // Write transfer: wq[0] is the pointer byte, the rest are data
  task automatic do_write();
    bit a;
    start_c();
    send_byte(addr_byte(mstrap, 1'b0), a);
    chk("R2 write address ack", a, 1);
    send_byte(wq[0], a);
    chk("R4 pointer byte ack", a, 1);
    mptr = wq[0][6:0];
    minc = wq[0][7];
    for (int i = 1; i < wq.size(); i++) begin
      send_byte(wq[i], a);
      chk("R5 data byte ack", a, 1);
      if (mptr < NUM_REGS) mregs[mptr] = wq[i];
      if (minc) mptr = (mptr + 1) % 128;
    end
    stop_c();
  endtask

  task automatic do_read(int n, string req);
    bit a;
    logic [7:0] d;
    start_c();
    send_byte(addr_byte(mstrap, 1'b1), a);
    chk("R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(req, d, model_read());
      if (minc) mptr = (mptr + 1) % 128;
    end
    wt(Q);
    chk("R6 released after NACK", sda_oe, 0);
    stop_c();
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) mregs[i] = 0;
    mstrap = {strap_hi, strap_lo};
    wt(5);
    rst_n = 1'b1;
    wt(4);
    // R1
    chk("R1 sda_oe after reset", sda_oe, 0);
    do_read(2, "R1 reset register value");

    // R5 auto-increment write, R7 pointer-only write, R6 read sequence
    wq = {8'h81, 8'h11, 8'h22, 8'h33};
    do_write();
    wq = {8'h81};
    do_write();
    chk("R7 pointer kept after aborted write", mptr, 1);
    do_read(3, "R6 auto-increment read data");

    // R5 no auto-increment: overwrite same register
    wq = {8'h05, 8'hAA, 8'hBB};
    do_write();
    wq = {8'h05};
    do_write();
    do_read(2, "R5 non-incrementing read data");

    // R10 pointer wrap and out-of-range access
    wq = {8'hFF, 8'h77, 8'h66};
    do_write();
    wq = {8'hFE};
    do_write();
    do_read(3, "R10 wrap and out-of-range read");

    // R3 address mismatch: wrong prefix and wrong strap
    start_c();
    send_byte(8'b1001_0100, a);
    chk("R3 wrong prefix not acked", a, 0);
    send_byte(8'h55, a);
    chk("R3 following byte not acked", a, 0);
    stop_c();
    start_c();
    send_byte(addr_byte(~mstrap, 1'b0), a);
    chk("R3 wrong strap not acked", a, 0);
    send_byte(8'h80, a);
    chk("R3 pointer byte ignored", a, 0);
    send_byte(8'h99, a);
    stop_c();
    wq = {8'h80};
    do_write();
    do_read(2, "R3 registers untouched by mismatch");

    // R8 repeated START inside a data byte
    start_c();
    send_byte(addr_byte(mstrap, 1'b0), a);
    chk("R8 address ack", a, 1);
    send_byte(8'h82, a);
    chk("R8 pointer ack", a, 1);
    mptr = 2;
    minc = 1;
    for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
    start_c();
    send_byte(addr_byte(mstrap, 1'b1), a);
    chk("R8 address after repeated start", a, 1);
    recv_byte(1'b0, d);
    chk("R8 partial byte not written", d, model_read());
    mptr = (mptr + 1) % 128;
    stop_c();

    // R9 straps changed after reset have no effect
    strap_hi = ~strap_hi;
    strap_lo = ~strap_lo;
    wt(4);
    start_c();
    send_byte(addr_byte(~mstrap, 1'b1), a);
    chk("R9 new strap address ignored", a, 0);
    stop_c();
    wq = {8'h83, 8'h5A};
    do_write();
    wq = {8'h03};
    do_write();
    do_read(1, "R9 latched address still active");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule